// File: doc/BRIEF.md
# Dual-Mode General Purpose Timer

This block is a register-programmed timer built from two 16-bit halves. Software picks a configuration. Configuration 0 joins the halves into one 32-bit down-counter that runs either once or repeatedly. Configuration 1 turns them into a 32-bit seconds counter that advances on an external once-per-second strobe and compares against a 32-bit match value. Configurations 4 and above select split operation, in which only the second half's enable bit takes effect. Each 32-bit load or match value is held as two 16-bit halves. A write to the A register fills both halves, and a write to the B register replaces the upper half only.

Events set bits in a raw status register. Software clears them by writing ones to a clear register. A level interrupt is high whenever any raw status bit is also enabled in the mask. A countdown timeout can also emit a one-clock pulse meant to start an ADC conversion.

The register bus is a plain single-cycle interface. A write is taken on the clock edge at which `bus_wr` is high. Read data follows `bus_addr` combinationally, and reads have no side effects. There is no back-pressure: every access completes at once.

Register word offsets: 0x00 configuration (3 bits), 0x04 control, 0x08 mode A, 0x0C mode B, 0x10 load A, 0x14 load B, 0x18 match A, 0x1C match B, 0x20 interrupt mask, 0x24 interrupt clear, 0x28 raw status, 0x2C masked status, 0x30 prescale A, 0x34 prescale B. The prescale registers are storage only. Unmapped reads return 0.

Control bits: bit 0 enables timer A, bit 5 enables the ADC trigger, bit 8 enables timer B. Status bits: bit 0 is the countdown timeout, bit 1 is the seconds-counter match.

Top module: `gpt_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `adc_trig` are low.
- R2: In configuration 0, raw status bit 0 becomes set exactly L clock edges after the write edge that sets control bit 0, where L is the upper load half times 65536 plus the lower load half.
- R3: When mode A bit 0 is 0 (periodic), the counter reloads L at each timeout, so each further timeout follows the previous one by exactly L edges.
- R4: When mode A bit 0 is 1 (one-shot), control bit 0 clears at the timeout edge and no further timeout occurs.
- R5: With control bit 5 set, `adc_trig` is high for exactly the one cycle after a timeout edge. With bit 5 clear it stays low.
- R6: In configuration 1, each `pps_tick` pulse advances a seconds count while timer A is enabled. Status bit 1 is set on the pulse that brings the count equal to the 32-bit match value. Enabling timer A restarts the count at 0.
- R7: A mask write keeps only the bits of 0x77. `irq` is high exactly when raw status AND mask is nonzero, and the masked-status read returns that AND.
- R8: Writing ones to the clear register at 0x24 clears those status bits and leaves the others unchanged.
- R9: A load A write stores bits 15:0 in the lower half and bits 31:16 in the upper half. A load B write replaces only the upper half. The match registers behave the same way.
- R10: Load A and match A reads return the upper half in bits 31:16 only while the configuration is below 4. Otherwise those bits read 0.
- R11: A control write changes bit 8 only while the configuration is 4 or higher. Otherwise bit 8 keeps its value.
- R12: Writes to configuration and mode registers are ignored while control bit 0 or bit 8 is set.
- R13: Clearing control bit 0 halts the countdown with no timeout. Setting it again reloads the full value L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pps_tick | input | 1 | One-pulse-per-second strobe for the seconds counter |
| irq | output | 1 | Level interrupt: raw status AND mask is nonzero |
| adc_trig | output | 1 | One-cycle ADC start pulse on countdown timeout |

## Verification
The bench builds the block with its default 16-bit halves and 3-bit configuration field. Small load values (2 to 9) and match values (1 to 5) then bring every timeout and match within a few cycles. This lets the bench sweep each value and compare the exact edge of every event against arithmetic. In the same way it covers periodic reload distance, one-shot self-disable, trigger pulse width, mid-count stop and restart, and seconds-counter restart between sweeps.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_CFG     = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h04;
  localparam logic [ADDR_W-1:0] A_MODE_A  = 6'h08;
  localparam logic [ADDR_W-1:0] A_MODE_B  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_LOAD_A  = 6'h10;
  localparam logic [ADDR_W-1:0] A_LOAD_B  = 6'h14;
  localparam logic [ADDR_W-1:0] A_MATCH_A = 6'h18;
  localparam logic [ADDR_W-1:0] A_MATCH_B = 6'h1C;
  localparam logic [ADDR_W-1:0] A_IMASK   = 6'h20;
  localparam logic [ADDR_W-1:0] A_ICLR    = 6'h24;
  localparam logic [ADDR_W-1:0] A_RAW     = 6'h28;
  localparam logic [ADDR_W-1:0] A_MASKED  = 6'h2C;
  localparam logic [ADDR_W-1:0] A_PRE_A   = 6'h30;
  localparam logic [ADDR_W-1:0] A_PRE_B   = 6'h34;

  localparam int STAT_W = 7;
  localparam logic [STAT_W-1:0] IMASK_KEEP = 7'h77;
  localparam int ST_TMO = 0;
  localparam int ST_RTC = 1;

  localparam int CTL_EN_A = 0;
  localparam int CTL_TRIG = 5;
  localparam int CTL_EN_B = 8;

  localparam int CFG_CNT32 = 0;
  localparam int CFG_RTC   = 1;
  localparam int CFG_SPLIT = 4;
endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int CFG_W  = 3,
  parameter int MODE_W = 4,
  parameter int CTRL_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [2*HALF_W-1:0] bus_wdata,
  input  logic                oneshot_done,
  input  logic [STAT_W-1:0]   status,
  output logic [CFG_W-1:0]    cfg,
  output logic [MODE_W-1:0]   mode_a,
  output logic [CTRL_W-1:0]   ctrl,
  output logic [2*HALF_W-1:0] load_val,
  output logic [2*HALF_W-1:0] match_val,
  output logic [STAT_W-1:0]   imask,
  output logic                start_a,
  output logic [STAT_W-1:0]   clr_bits,
  output logic [2*HALF_W-1:0] rdata
);
  localparam int DATA_W = 2 * HALF_W;

  logic [MODE_W-1:0] mode_b;
  logic [HALF_W-1:0] load_lo, load_hi, match_lo, match_hi;
  logic [PRE_W-1:0]  pre_a, pre_b;
  logic [CTRL_W-1:0] ctrl_nxt;
  logic busy, split;

  assign busy  = ctrl[CTL_EN_A] | ctrl[CTL_EN_B];
  assign split = (cfg >= CFG_W'(CFG_SPLIT));

  logic sel_cfg, sel_ctrl, sel_ma, sel_mb, sel_la, sel_lb, sel_xa, sel_xb;
  logic sel_msk, sel_clr, sel_pa, sel_pb;
  assign sel_cfg  = bus_wr && (bus_addr == A_CFG);
  assign sel_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign sel_ma   = bus_wr && (bus_addr == A_MODE_A);
  assign sel_mb   = bus_wr && (bus_addr == A_MODE_B);
  assign sel_la   = bus_wr && (bus_addr == A_LOAD_A);
  assign sel_lb   = bus_wr && (bus_addr == A_LOAD_B);
  assign sel_xa   = bus_wr && (bus_addr == A_MATCH_A);
  assign sel_xb   = bus_wr && (bus_addr == A_MATCH_B);
  assign sel_msk  = bus_wr && (bus_addr == A_IMASK);
  assign sel_clr  = bus_wr && (bus_addr == A_ICLR);
  assign sel_pa   = bus_wr && (bus_addr == A_PRE_A);
  assign sel_pb   = bus_wr && (bus_addr == A_PRE_B);

  assign start_a  = sel_ctrl && bus_wdata[CTL_EN_A] && !ctrl[CTL_EN_A];
  assign clr_bits = sel_clr ? bus_wdata[STAT_W-1:0] : '0;

  always_comb begin
    ctrl_nxt = ctrl;
    if (sel_ctrl) begin
      ctrl_nxt = bus_wdata[CTRL_W-1:0];
      if (!split) ctrl_nxt[CTL_EN_B] = ctrl[CTL_EN_B];
    end else if (oneshot_done) begin
      ctrl_nxt[CTL_EN_A] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      mode_a   <= '0;
      mode_b   <= '0;
      ctrl     <= '0;
      load_lo  <= '0;
      load_hi  <= '0;
      match_lo <= '0;
      match_hi <= '0;
      imask    <= '0;
      pre_a    <= '0;
      pre_b    <= '0;
    end else begin
      ctrl <= ctrl_nxt;
      if (sel_cfg && !busy) cfg    <= bus_wdata[CFG_W-1:0];
      if (sel_ma  && !busy) mode_a <= bus_wdata[MODE_W-1:0];
      if (sel_mb  && !busy) mode_b <= bus_wdata[MODE_W-1:0];
      if (sel_la) begin
        load_lo <= bus_wdata[HALF_W-1:0];
        load_hi <= bus_wdata[DATA_W-1:HALF_W];
      end else if (sel_lb) begin
        load_hi <= bus_wdata[HALF_W-1:0];
      end
      if (sel_xa) begin
        match_lo <= bus_wdata[HALF_W-1:0];
        match_hi <= bus_wdata[DATA_W-1:HALF_W];
      end else if (sel_xb) begin
        match_hi <= bus_wdata[HALF_W-1:0];
      end
      if (sel_msk) imask <= bus_wdata[STAT_W-1:0] & IMASK_KEEP;
      if (sel_pa)  pre_a <= bus_wdata[PRE_W-1:0];
      if (sel_pb)  pre_b <= bus_wdata[PRE_W-1:0];
    end
  end

  assign load_val  = {load_hi, load_lo};
  assign match_val = {match_hi, match_lo};

  always_comb begin
    rdata = '0;
    unique case (bus_addr)
      A_CFG:     rdata = DATA_W'(cfg);
      A_CTRL:    rdata = DATA_W'(ctrl);
      A_MODE_A:  rdata = DATA_W'(mode_a);
      A_MODE_B:  rdata = DATA_W'(mode_b);
      A_LOAD_A:  rdata = {split ? '0 : load_hi, load_lo};
      A_LOAD_B:  rdata = DATA_W'(load_hi);
      A_MATCH_A: rdata = {split ? '0 : match_hi, match_lo};
      A_MATCH_B: rdata = DATA_W'(match_hi);
      A_IMASK:   rdata = DATA_W'(imask);
      A_RAW:     rdata = DATA_W'(status);
      A_MASKED:  rdata = DATA_W'(status & imask);
      A_PRE_A:   rdata = DATA_W'(pre_a);
      A_PRE_B:   rdata = DATA_W'(pre_b);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpt_count.sv
module gpt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             oneshot,
  input  logic             trig_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             timeout,
  output logic             adc_trig
);
  logic [CNT_W-1:0] cnt;

  assign timeout = run && !start && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      adc_trig <= 1'b0;
    end else begin
      adc_trig <= timeout && trig_en;
      if (start)        cnt <= load_val;
      else if (timeout) cnt <= oneshot ? '0 : load_val;
      else if (run)     cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/gpt_rtc.sv
module gpt_rtc #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             pps_tick,
  input  logic [CNT_W-1:0] match_val,
  output logic             hit
);
  logic [CNT_W-1:0] secs;
  logic [CNT_W-1:0] secs_inc;

  assign secs_inc = secs + CNT_W'(1);
  assign hit = run && !start && pps_tick && (secs_inc == match_val);

  always_ff @(posedge clk) begin
    if (!rst_n)                secs <= '0;
    else if (start)            secs <= '0;
    else if (run && pps_tick)  secs <= secs_inc;
  end
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
  parameter int STAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_bits,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic [STAT_W-1:0] imask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_bits) | set_bits;
  end

  assign irq = |(status & imask);
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int CFG_W  = 3,
  parameter int MODE_W = 4,
  parameter int CTRL_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [2*HALF_W-1:0] bus_wdata,
  output logic [2*HALF_W-1:0] bus_rdata,
  input  logic                pps_tick,
  output logic                irq,
  output logic                adc_trig
);
  localparam int DATA_W = 2 * HALF_W;

  logic [CFG_W-1:0]  cfg;
  logic [MODE_W-1:0] mode_a;
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] load_val, match_val;
  logic [STAT_W-1:0] imask, clr_bits, status, set_bits;
  logic start_a, timeout, rtc_hit, oneshot;
  logic is_cnt, is_rtc;

  assign is_cnt  = (cfg == CFG_W'(CFG_CNT32));
  assign is_rtc  = (cfg == CFG_W'(CFG_RTC));
  assign oneshot = mode_a[0];

  gpt_regs #(
    .HALF_W(HALF_W), .CFG_W(CFG_W), .MODE_W(MODE_W),
    .CTRL_W(CTRL_W), .PRE_W(PRE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .oneshot_done(timeout && oneshot),
    .status(status), .cfg(cfg), .mode_a(mode_a), .ctrl(ctrl),
    .load_val(load_val), .match_val(match_val), .imask(imask),
    .start_a(start_a), .clr_bits(clr_bits), .rdata(bus_rdata)
  );

  gpt_count #(.CNT_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .start(start_a && is_cnt),
    .run(ctrl[CTL_EN_A] && is_cnt),
    .oneshot(oneshot), .trig_en(ctrl[CTL_TRIG]),
    .load_val(load_val), .timeout(timeout), .adc_trig(adc_trig)
  );

  gpt_rtc #(.CNT_W(DATA_W)) u_rtc (
    .clk(clk), .rst_n(rst_n),
    .start(start_a && is_rtc),
    .run(ctrl[CTL_EN_A] && is_rtc),
    .pps_tick(pps_tick), .match_val(match_val), .hit(rtc_hit)
  );

  always_comb begin
    set_bits = '0;
    set_bits[ST_TMO] = timeout;
    set_bits[ST_RTC] = rtc_hit;
  end

  gpt_irq #(.STAT_W(STAT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_bits(clr_bits),
    .imask(imask), .status(status), .irq(irq)
  );
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk
  import gpt_pkg::*;
#(
  parameter int CFG_W  = 3,
  parameter int CTRL_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CFG_W-1:0]  cfg,
  input logic [CTRL_W-1:0] ctrl,
  input logic [STAT_W-1:0] status,
  input logic              timeout,
  input logic              oneshot,
  input logic              adc_trig
);
  // R2
  tmo_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> status[ST_TMO]);

  // R4
  oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && oneshot && !(bus_wr && bus_addr == A_CTRL)) |=> !ctrl[CTL_EN_A]);

  // R5
  trig_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |=> !adc_trig);

  // R5
  trig_with_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> status[ST_TMO]);

  // R8
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ICLR && bus_wdata[ST_TMO] && !timeout) |=> !status[ST_TMO]);

  // R11
  en_b_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && cfg < CFG_W'(CFG_SPLIT)) |=> $stable(ctrl[CTL_EN_B]));

  // R12
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl[CTL_EN_A] || ctrl[CTL_EN_B]) && bus_wr && bus_addr == A_CFG) |=> $stable(cfg));
endmodule

bind gpt_timer gpt_timer_chk #(.CFG_W(CFG_W), .CTRL_W(CTRL_W), .DATA_W(2*HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cfg(cfg), .ctrl(ctrl), .status(status),
  .timeout(timeout), .oneshot(oneshot), .adc_trig(adc_trig)
);

// File: tb/tb_gpt_timer.sv
module tb_gpt_timer;
  import gpt_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pps_tick = 1'b0;
  logic        irq, adc_trig;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpt_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pps_tick(pps_tick),
    .irq(irq), .adc_trig(adc_trig)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wait_stat(input int b, output int k);
    logic [31:0] v;
    k = 0;
    rd(A_RAW, v);
    while (!v[b] && k < 300) begin
      @(posedge clk); @(negedge clk); #0;
      k++;
      rd(A_RAW, v);
    end
  endtask

  task automatic pulse_pps();
    pps_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    pps_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(A_CFG, v);    chk("R1 cfg", v, 0);
    rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
    rd(A_LOAD_A, v); chk("R1 load", v, 0);
    rd(A_RAW, v);    chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 trig", {31'b0, adc_trig}, 0);

    // R7 mask keep bits
    wr(A_IMASK, 32'hFF); rd(A_IMASK, v); chk("R7 mask keep", v, 32'h77);
    wr(A_IMASK, 32'h0);

    // R9 split halves
    wr(A_LOAD_A, 32'h1234_5678);
    rd(A_LOAD_A, v); chk("R9 load A", v, 32'h1234_5678);
    rd(A_LOAD_B, v); chk("R9 load B upper", v, 32'h1234);
    wr(A_LOAD_B, 32'hABCD);
    rd(A_LOAD_A, v); chk("R9 load B only upper", v, 32'hABCD_5678);
    wr(A_MATCH_A, 32'h0002_0003);
    rd(A_MATCH_B, v); chk("R9 match B", v, 32'h2);
    wr(A_MATCH_B, 32'h0009);
    rd(A_MATCH_A, v); chk("R9 match B only upper", v, 32'h0009_0003);

    // R10 upper hidden in split configs
    wr(A_CFG, 4);
    rd(A_LOAD_A, v);  chk("R10 load A split", v, 32'h5678);
    rd(A_MATCH_A, v); chk("R10 match A split", v, 32'h0003);

    // R11 enable B only when split; R12 cfg locked while B enabled
    wr(A_CTRL, 32'h100); rd(A_CTRL, v); chk("R11 en B split", v, 32'h100);
    wr(A_CFG, 0); rd(A_CFG, v); chk("R12 cfg locked by B", v, 4);
    wr(A_CTRL, 0); wr(A_CFG, 0);
    wr(A_CTRL, 32'h100); rd(A_CTRL, v); chk("R11 en B ignored cfg0", v, 0);

    // R2 R3 R5 periodic sweep
    for (int L = 2; L <= 9; L++) begin
      logic te;
      te = L[0];
      wr(A_LOAD_A, L); wr(A_MODE_A, 0); wr(A_ICLR, 32'h7F);
      wr(A_CTRL, 32'h1 | (32'(te) << 5));
      wait_stat(ST_TMO, k);
      chk("R2 first timeout edge", k, L);
      chk("R5 trig at timeout", {31'b0, adc_trig}, {31'b0, te});
      wr(A_ICLR, 32'h1);
      chk("R5 trig one cycle", {31'b0, adc_trig}, 0);
      wait_stat(ST_TMO, k);
      chk("R3 reload interval", k, L - 1);
      wr(A_CTRL, 0); wr(A_ICLR, 32'h7F);
    end

    // R4 one-shot
    wr(A_LOAD_A, 3); wr(A_MODE_A, 1); wr(A_CTRL, 1);
    wait_stat(ST_TMO, k);
    chk("R4 one-shot timeout", k, 3);
    rd(A_CTRL, v); chk("R4 enable cleared", v & 1, 0);
    wr(A_ICLR, 32'h7F); step(12);
    rd(A_RAW, v); chk("R4 no second timeout", v & 1, 0);

    // R12 and R13 stop mid-count
    wr(A_MODE_A, 0); wr(A_LOAD_A, 6); wr(A_CTRL, 1);
    wr(A_CFG, 1);    rd(A_CFG, v);    chk("R12 cfg locked", v, 0);
    wr(A_MODE_A, 1); rd(A_MODE_A, v); chk("R12 mode locked", v, 0);
    wr(A_CTRL, 0); step(20);
    rd(A_RAW, v); chk("R13 halted no timeout", v & 1, 0);
    wr(A_CTRL, 1);
    wait_stat(ST_TMO, k);
    chk("R13 restart full reload", k, 6);
    wr(A_CTRL, 0);

    // R7 interrupt gating, R8 selective clear
    chk("R7 irq masked off", {31'b0, irq}, 0);
    rd(A_MASKED, v); chk("R7 masked read zero", v, 0);
    wr(A_IMASK, 1);
    chk("R7 irq on", {31'b0, irq}, 1);
    rd(A_MASKED, v); chk("R7 masked read", v, 1);
    wr(A_ICLR, 32'h2);
    rd(A_RAW, v); chk("R8 other bit kept", v & 1, 1);
    wr(A_ICLR, 32'h1);
    rd(A_RAW, v); chk("R8 bit cleared", v, 0);
    chk("R7 irq off after clear", {31'b0, irq}, 0);

    // R6 seconds counter sweep, restart each time
    wr(A_CFG, 1);
    for (int m = 1; m <= 5; m++) begin
      wr(A_CTRL, 0); wr(A_ICLR, 32'h7F);
      wr(A_MATCH_A, m); wr(A_CTRL, 1);
      for (int n = 1; n <= m; n++) begin
        pulse_pps();
        rd(A_RAW, v);
        chk("R6 match on pulse", (v >> 1) & 1, (n == m) ? 1 : 0);
      end
      chk("R5 no trig in rtc", {31'b0, adc_trig}, 0);
    end
    wr(A_CTRL, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule